// File: doc/BRIEF.md
# Segment Write-Access Violation Checker

This block decides whether a read-modify-write operand access to a segment is allowed. It compares a segment descriptor against the calling procedure's pointer and the target pointer. The descriptor supplies three ring brackets, read and write permission flags and a 14-bit bound. The procedure pointer supplies a ring and a segment number. The target pointer supplies a ring, a segment number and an 18-bit computed address.

All violation tests run on every request. Their results are merged into one 16-bit mask, so the downstream fault logic sees every problem at once and not only the first one found. Some tests replace the effective ring with the procedure ring, and tests that come later in the order use the replaced value. The final effective ring is an output of the block.

A one-cycle start strobe loads a request. One cycle later the block registers the mask and the effective ring, pulses done, and pulses a fault request if any mask bit is set. The outputs then hold until the next start.

Top module: `seg_rmw_acc_chk`

## Requirements
- R1: When the brackets do not satisfy r1 <= r2 <= r3, mask bit 0 is set.
- R2: When the incoming target ring is greater than r2, mask bit 3 is set. This test uses the target ring before any replacement.
- R3: When the read flag is 0, the effective ring becomes the procedure ring. If the procedure segment also differs from the target segment, mask bit 4 is set.
- R4: When the target segment equals the procedure segment, the effective ring becomes the procedure ring. After that replacement, and after the one in R3, mask bit 5 is set if the effective ring is greater than r1.
- R5: When the write flag is 0, mask bit 6 is set and the effective ring becomes the procedure ring. This replacement comes after the r1 test of R4, so it does not affect that test.
- R6: When address bits 17:4 are greater than the bound, mask bit 15 is set. When they are equal to the bound, the bit stays clear.
- R7: The mask is 16 bits wide and indexed by violation number. Bits 1, 2 and 7 to 14 always read 0.
- R8: Results are registered on the clock edge that samples start_i high. In the cycle that follows, done_o pulses for one cycle. fault_o pulses in that same cycle only if the mask is nonzero, and is low at every other time. With no start, the mask and the effective ring hold their values.
- R9: eff_ring_o shows the effective ring after all replacements. When no replacement applies, it equals the incoming target ring.
- R10: While rst_ni is low, done_o, fault_o, viol_mask_o and eff_ring_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; the inputs below are sampled with it |
| r1_i | input | 3 | Descriptor bracket r1 |
| r2_i | input | 3 | Descriptor bracket r2 |
| r3_i | input | 3 | Descriptor bracket r3 |
| rd_ok_i | input | 1 | Descriptor read permission |
| wr_ok_i | input | 1 | Descriptor write permission |
| bound_i | input | 14 | Descriptor bound, in 16-word units |
| prr_i | input | 3 | Procedure ring |
| psr_i | input | 15 | Procedure segment number |
| trr_i | input | 3 | Target ring |
| tsr_i | input | 15 | Target segment number |
| ca_i | input | 18 | Computed address inside the segment |
| done_o | output | 1 | Result-valid pulse |
| fault_o | output | 1 | Access-violation fault request pulse |
| viol_mask_o | output | 16 | Accumulated violation mask |
| eff_ring_o | output | 3 | Adjusted effective ring |

## Verification
The bench targets the ordering of the ring replacements.

- One vector has a same-segment replacement that lowers a high target ring below r1. A design that tests r1 before the replacement would raise bit 5 there by mistake.
- Another vector has the write-flag replacement raise the ring above r1. A design that applies that replacement before the r1 test would also set bit 5 wrongly.
- One vector puts the target ring above r2 while the read flag is off. This catches a bit-3 test that uses the replaced ring instead of the incoming one.
- The bound is tested at equality, at one above, and with the low four address bits all set. This exposes a comparator that uses >= or takes the wrong address slice.
- Directed tests cover input changes with no start (nothing may move), back-to-back starts, and a reset after a result has been registered.

// File: rtl/seg_acc_pkg.sv
package seg_acc_pkg;
  localparam int unsigned MASK_W      = 16;
  localparam int unsigned VB_BRACKET  = 0;
  localparam int unsigned VB_ABOVE_R2 = 3;
  localparam int unsigned VB_NOREAD   = 4;
  localparam int unsigned VB_ABOVE_R1 = 5;
  localparam int unsigned VB_NOWRITE  = 6;
  localparam int unsigned VB_BOUND    = 15;

  typedef logic [MASK_W-1:0] viol_mask_t;

  localparam viol_mask_t USED_BITS = viol_mask_t'((1 << VB_BRACKET) | (1 << VB_ABOVE_R2) |
                                                  (1 << VB_NOREAD) | (1 << VB_ABOVE_R1) |
                                                  (1 << VB_NOWRITE) | (1 << VB_BOUND));
endpackage

// File: rtl/seg_ring_eval.sv
module seg_ring_eval
  import seg_acc_pkg::*;
#(
  parameter int unsigned RING_W = 3,
  parameter int unsigned SEG_W  = 15
) (
  input  logic [RING_W-1:0] r1_i,
  input  logic [RING_W-1:0] r2_i,
  input  logic [RING_W-1:0] r3_i,
  input  logic              rd_ok_i,
  input  logic              wr_ok_i,
  input  logic [RING_W-1:0] prr_i,
  input  logic [SEG_W-1:0]  psr_i,
  input  logic [RING_W-1:0] trr_i,
  input  logic [SEG_W-1:0]  tsr_i,
  output viol_mask_t        mask_o,
  output logic [RING_W-1:0] ring_o
);
  logic              same_seg;
  logic [RING_W-1:0] ring_rd;
  logic [RING_W-1:0] ring_r1;

  assign same_seg = (psr_i == tsr_i);

  // Replacement order matters: read flag, then same segment, then r1 test, then write flag.
  always_comb begin
    ring_rd = rd_ok_i  ? trr_i   : prr_i;
    ring_r1 = same_seg ? prr_i   : ring_rd;
    ring_o  = wr_ok_i  ? ring_r1 : prr_i;
  end

  always_comb begin
    mask_o              = '0;
    mask_o[VB_BRACKET]  = !((r1_i <= r2_i) && (r2_i <= r3_i));
    mask_o[VB_ABOVE_R2] = trr_i > r2_i;
    mask_o[VB_NOREAD]   = !rd_ok_i && !same_seg;
    mask_o[VB_ABOVE_R1] = ring_r1 > r1_i;
    mask_o[VB_NOWRITE]  = !wr_ok_i;
  end
endmodule

// File: rtl/seg_bound_cmp.sv
module seg_bound_cmp #(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BOUND_W = 14
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BOUND_W-1:0] bound_i,
  output logic               over_o
);
  localparam int unsigned BLK_LSB = ADDR_W - BOUND_W;

  logic unused_offset;
  assign unused_offset = ^addr_i[BLK_LSB-1:0];

  assign over_o = addr_i[ADDR_W-1:BLK_LSB] > bound_i;
endmodule

// File: rtl/seg_rmw_acc_chk.sv
module seg_rmw_acc_chk
  import seg_acc_pkg::*;
#(
  parameter int unsigned RING_W  = 3,
  parameter int unsigned SEG_W   = 15,
  parameter int unsigned BOUND_W = 14,
  parameter int unsigned ADDR_W  = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RING_W-1:0]  r1_i,
  input  logic [RING_W-1:0]  r2_i,
  input  logic [RING_W-1:0]  r3_i,
  input  logic               rd_ok_i,
  input  logic               wr_ok_i,
  input  logic [BOUND_W-1:0] bound_i,
  input  logic [RING_W-1:0]  prr_i,
  input  logic [SEG_W-1:0]   psr_i,
  input  logic [RING_W-1:0]  trr_i,
  input  logic [SEG_W-1:0]   tsr_i,
  input  logic [ADDR_W-1:0]  ca_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [MASK_W-1:0]  viol_mask_o,
  output logic [RING_W-1:0]  eff_ring_o
);
  viol_mask_t        ring_mask;
  logic              bound_over;
  viol_mask_t        mask_d;
  logic [RING_W-1:0] ring_d;

  seg_ring_eval #(.RING_W(RING_W), .SEG_W(SEG_W)) u_ring (
    .r1_i    (r1_i),
    .r2_i    (r2_i),
    .r3_i    (r3_i),
    .rd_ok_i (rd_ok_i),
    .wr_ok_i (wr_ok_i),
    .prr_i   (prr_i),
    .psr_i   (psr_i),
    .trr_i   (trr_i),
    .tsr_i   (tsr_i),
    .mask_o  (ring_mask),
    .ring_o  (ring_d)
  );

  seg_bound_cmp #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_bound (
    .addr_i  (ca_i),
    .bound_i (bound_i),
    .over_o  (bound_over)
  );

  always_comb begin
    mask_d           = ring_mask;
    mask_d[VB_BOUND] = bound_over;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      viol_mask_o <= '0;
      eff_ring_o  <= '0;
    end else begin
      done_o  <= start_i;
      fault_o <= start_i && (mask_d != '0);
      if (start_i) begin
        viol_mask_o <= mask_d;
        eff_ring_o  <= ring_d;
      end
    end
  end
endmodule

// File: rtl/seg_rmw_acc_chk_sva.sv
module seg_rmw_acc_chk_sva
  import seg_acc_pkg::*;
#(
  parameter int unsigned RING_W  = 3,
  parameter int unsigned SEG_W   = 15,
  parameter int unsigned BOUND_W = 14,
  parameter int unsigned ADDR_W  = 18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [RING_W-1:0]  r1_i,
  input logic [RING_W-1:0]  r2_i,
  input logic [RING_W-1:0]  r3_i,
  input logic               rd_ok_i,
  input logic               wr_ok_i,
  input logic [BOUND_W-1:0] bound_i,
  input logic [RING_W-1:0]  prr_i,
  input logic [SEG_W-1:0]   psr_i,
  input logic [RING_W-1:0]  trr_i,
  input logic [SEG_W-1:0]   tsr_i,
  input logic [ADDR_W-1:0]  ca_i,
  input logic               done_o,
  input logic               fault_o,
  input logic [MASK_W-1:0]  viol_mask_o,
  input logic [RING_W-1:0]  eff_ring_o
);
  localparam int unsigned BLK_LSB = ADDR_W - BOUND_W;

  assert_bracket_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> viol_mask_o[VB_BRACKET] == !(($past(r1_i) <= $past(r2_i)) && ($past(r2_i) <= $past(r3_i))));

  assert_above_r2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> viol_mask_o[VB_ABOVE_R2] == ($past(trr_i) > $past(r2_i)));

  assert_noread_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !rd_ok_i && (psr_i != tsr_i)) |=> viol_mask_o[VB_NOREAD]);

  assert_same_seg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && rd_ok_i && wr_ok_i && (psr_i == tsr_i)) |=>
      (eff_ring_o == $past(prr_i)) && (viol_mask_o[VB_ABOVE_R1] == ($past(prr_i) > $past(r1_i))));

  assert_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wr_ok_i) |=> viol_mask_o[VB_NOWRITE] && (eff_ring_o == $past(prr_i)));

  assert_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> viol_mask_o[VB_BOUND] == ($past(ca_i[ADDR_W-1:BLK_LSB]) > $past(bound_i)));

  assert_unused_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_mask_o & ~USED_BITS) == '0);

  assert_done_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i));

  assert_fault_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

  assert_fault_iff_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o == (viol_mask_o != '0)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(viol_mask_o) && $stable(eff_ring_o) && !done_o);

  assert_plain_ring_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && rd_ok_i && wr_ok_i && (psr_i != tsr_i)) |=> eff_ring_o == $past(trr_i));
endmodule

bind seg_rmw_acc_chk seg_rmw_acc_chk_sva #(
  .RING_W(RING_W), .SEG_W(SEG_W), .BOUND_W(BOUND_W), .ADDR_W(ADDR_W)
) u_sva (.*);

// File: tb/sim_seg_rmw_acc_chk.sv
`timescale 1ns/1ps
module sim_seg_rmw_acc_chk;
  typedef struct packed {
    logic [2:0]  r1, r2, r3;
    logic        rd, wr;
    logic [13:0] bound;
    logic [2:0]  prr;
    logic [14:0] psr;
    logic [2:0]  trr;
    logic [14:0] tsr;
    logic [17:0] ca;
    logic [15:0] exp_mask;
    logic [2:0]  exp_ring;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // all clear
    '{3'd4, 3'd4, 3'd5, 1'b1, 1'b1, 14'd10, 3'd2, 15'd100, 3'd3, 15'd200, 18'h00050, 16'h0000, 3'd3},
    // R1 bracket out of order
    '{3'd5, 3'd3, 3'd6, 1'b1, 1'b1, 14'd10, 3'd1, 15'd7, 3'd2, 15'd8, 18'h00000, 16'h0001, 3'd2},
    // R2 and R4: ring above r2 and r1; R6 at bound equality
    '{3'd1, 3'd2, 3'd3, 1'b1, 1'b1, 14'd3, 3'd0, 15'd7, 3'd5, 15'd9, 18'h00030, 16'h0028, 3'd5},
    // R3 read off, other segment; replaced ring trips r1
    '{3'd3, 3'd3, 3'd3, 1'b0, 1'b1, 14'd0, 3'd6, 15'd4, 3'd1, 15'd5, 18'h0000F, 16'h0030, 3'd6},
    // R3 read off, same segment, no fault
    '{3'd7, 3'd7, 3'd7, 1'b0, 1'b1, 14'd0, 3'd2, 15'd12, 3'd7, 15'd12, 18'h00000, 16'h0000, 3'd2},
    // R4 same segment lowers ring below r1
    '{3'd2, 3'd6, 3'd7, 1'b1, 1'b1, 14'd100, 3'd1, 15'd30, 3'd5, 15'd30, 18'h00000, 16'h0000, 3'd1},
    // R4 same segment raises ring above r1
    '{3'd2, 3'd6, 3'd7, 1'b1, 1'b1, 14'd100, 3'd4, 15'd3, 3'd0, 15'd3, 18'h00000, 16'h0020, 3'd4},
    // R5 write off after r1 test; R6 top address equal to bound
    '{3'd4, 3'd5, 3'd6, 1'b1, 1'b0, 14'h3FFF, 3'd7, 15'd1, 3'd3, 15'd2, 18'h3FFFF, 16'h0040, 3'd7},
    // R6 one block over bound
    '{3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 14'h1233, 3'd0, 15'd1, 3'd0, 15'd2, 18'h1234F, 16'h8000, 3'd0},
    // R7 every bit together
    '{3'd6, 3'd5, 3'd4, 1'b0, 1'b0, 14'd0, 3'd7, 15'd1, 3'd7, 15'd2, 18'h00010, 16'h8079, 3'd7}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  r1_i = '0, r2_i = '0, r3_i = '0, prr_i = '0, trr_i = '0;
  logic        rd_ok_i = 1'b0, wr_ok_i = 1'b0;
  logic [13:0] bound_i = '0;
  logic [14:0] psr_i = '0, tsr_i = '0;
  logic [17:0] ca_i = '0;
  logic        done_o, fault_o;
  logic [15:0] viol_mask_o;
  logic [2:0]  eff_ring_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  seg_rmw_acc_chk u0 (
    .clk_i, .rst_ni, .start_i, .r1_i, .r2_i, .r3_i, .rd_ok_i, .wr_ok_i, .bound_i,
    .prr_i, .psr_i, .trr_i, .tsr_i, .ca_i, .done_o, .fault_o, .viol_mask_o, .eff_ring_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    r1_i = v.r1; r2_i = v.r2; r3_i = v.r3; rd_ok_i = v.rd; wr_ok_i = v.wr;
    bound_i = v.bound; prr_i = v.prr; psr_i = v.psr; trr_i = v.trr; tsr_i = v.tsr; ca_i = v.ca;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    @(negedge clk_i);
    apply(v);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({tag, " R8 done"}, 32'(done_o), 32'd1);
    check({tag, " R7 mask"}, 32'(viol_mask_o), 32'(v.exp_mask));
    check({tag, " R9 ring"}, 32'(eff_ring_o), 32'(v.exp_ring));
    check({tag, " R8 fault"}, 32'(fault_o), 32'(v.exp_mask != 0));
    @(negedge clk_i);
    check({tag, " R8 done pulse"}, 32'(done_o), 32'd0);
    check({tag, " R8 fault pulse"}, 32'(fault_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 done", 32'(done_o), 32'd0);
    check("R10 fault", 32'(fault_o), 32'd0);
    check("R10 mask", 32'(viol_mask_o), 32'd0);
    check("R10 ring", 32'(eff_ring_o), 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R8 hold: new inputs without start change nothing
    @(negedge clk_i);
    apply(VECS[1]);
    repeat (2) @(negedge clk_i);
    check("R8 hold mask", 32'(viol_mask_o), 32'h8079);
    check("R8 hold ring", 32'(eff_ring_o), 32'd7);
    check("R8 hold done", 32'(done_o), 32'd0);
    check("R8 hold fault", 32'(fault_o), 32'd0);

    // R8 back-to-back starts
    @(negedge clk_i);
    apply(VECS[6]);
    start_i = 1'b1;
    @(negedge clk_i);
    check("R4 b2b first mask", 32'(viol_mask_o), 32'h0020);
    check("R8 b2b first fault", 32'(fault_o), 32'd1);
    apply(VECS[5]);
    @(negedge clk_i);
    start_i = 1'b0;
    check("R8 b2b second done", 32'(done_o), 32'd1);
    check("R4 b2b second mask", 32'(viol_mask_o), 32'h0000);
    check("R8 b2b second fault", 32'(fault_o), 32'd0);
    check("R9 b2b second ring", 32'(eff_ring_o), 32'd1);

    // R10 reset after a registered result
    run_vec(VECS[9], "prereset");
    rst_ni = 1'b0;
    #1;
    check("R10 mid mask", 32'(viol_mask_o), 32'd0);
    check("R10 mid ring", 32'(eff_ring_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_vec(VECS[0], "postreset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule